// File: doc/BRIEF.md
# Queued SPI Command Sequencer

This block walks a 16-entry command queue and hands one entry at a time to a serial shift engine. Software programs a first-entry pointer, a last-entry pointer, a loop mode and a chip-select idle level, then pulses `go`. The sequencer presents the current entry index on `cmd_idx` with `cmd_valid` high. It waits for the engine to pulse `cmd_done`, records that index as the most recently completed entry, and moves on. The index of the current entry also addresses the command store, which returns that entry's chip-select pattern on `ent_cs`.

Execution ends in one of three ways. The last entry completes with looping off. A halt request lets the running entry finish and then stops the queue. With looping on, the queue never ends by itself and returns either to entry zero or to the first-entry pointer. Three sticky status flags record events: end-of-queue reached, a configuration write while busy, and a stop forced by halt. Each flag is cleared by writing one to it and has its own interrupt enable.

Top module: `cmdq_sequencer`

## Requirements
- R1: While idle, a one-cycle `go` pulse starts execution at the first-entry pointer (config register bits [3:0]). `busy` and `cmd_valid` go high on the next cycle. Each `cmd_done` without any stop condition advances `cmd_idx` by one, modulo 16.
- R2: With looping off (config bit 8 = 0), the queue stops after the entry equal to the last-entry pointer (config bits [7:4]) completes. A queue whose last pointer is below its first pointer runs through entry 15 and on to entry 0.
- R3: With looping on (config bit 8 = 1), completion of the last entry continues at entry 0 when config bit 9 is 0, or at the first-entry pointer when config bit 9 is 1.
- R4: While the halt bit (register 1, bit 0) is set, the next completion stops the queue and no further entry is issued. A halt stop that is not the natural end of a non-looping queue sets the abort flag (flags bit 2).
- R5: `done_ptr` holds the index of the most recently completed entry. It resets to 0.
- R6: While busy, `cs_out` equals `ent_cs`. Otherwise every `cs_out` bit equals the idle-level bit (config bit 10).
- R7: The end flag (flags bit 0) sets whenever the last-pointer entry completes, including on every pass when looping. Writing register 2 with a one in bits [6:4] clears flags bits [2:0] respectively.
- R8: A write to the config register (address 0) while busy is ignored and sets the collision flag (flags bit 1).
- R9: `irq` is high exactly when some flag is set and its enable bit in register 2 bits [2:0] is set. The enables are rewritten on every write to register 2.
- R10: After reset, `busy`, `cmd_valid`, `flags`, `irq`, `done_ptr` and `cs_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 config, 1 halt, 2 enables/clears |
| reg_wdata | input | 16 | Register write data |
| go | input | 1 | Start request (ignored while busy) |
| cmd_valid | output | 1 | Entry on cmd_idx is to be executed |
| cmd_idx | output | 4 | Current queue entry index |
| cmd_done | input | 1 | Engine completion pulse |
| ent_cs | input | 4 | Chip-select pattern of the current entry |
| cs_out | output | 4 | Chip-select outputs |
| busy | output | 1 | Queue executing |
| done_ptr | output | 4 | Last completed entry |
| flags | output | 3 | {abort, collision, end} status |
| irq | output | 1 | Interrupt request |

## Verification
The queue is run with a plain ascending range and with a range that crosses from entry 15 to entry 0. This separates correct modulo-16 stepping from a stop on a plain comparison. Looping runs with each wrap target show whether the return goes to zero or to the first pointer. A halt injected at a known completion count checks that exactly one further entry completes. A halt set before `go` checks that only the first entry runs. A config write during a run is followed by a rerun, which shows that the old pointers were kept.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int PTR_W = 4;
  localparam int NFLAG = 3;
  localparam int F_END = 0;
  localparam int F_COL = 1;
  localparam int F_ABT = 2;

  typedef enum logic {S_IDLE, S_RUN} seq_state_t;

  typedef struct packed {
    logic [PTR_W-1:0] first;
    logic [PTR_W-1:0] last;
    logic             loop_en;
    logic             loop_to_first;
    logic             cs_idle;
  } seq_cfg_t;
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             busy,
  input  logic             evt_end,
  input  logic             evt_abort,
  output seq_cfg_t         cfg,
  output logic             halt,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] irq_en,
  output logic             irq
);
  localparam int CLR_LSB = 4;

  seq_cfg_t         cfg_n;
  logic             halt_n;
  logic [NFLAG-1:0] flags_n, en_n, evt, clr;
  logic             wr_cfg, wr_halt, wr_irq;

  assign wr_cfg  = reg_we && (reg_addr == 2'd0);
  assign wr_halt = reg_we && (reg_addr == 2'd1);
  assign wr_irq  = reg_we && (reg_addr == 2'd2);

  always_comb begin
    evt        = '0;
    evt[F_END] = evt_end;
    evt[F_COL] = wr_cfg && busy;
    evt[F_ABT] = evt_abort;
    clr        = wr_irq ? reg_wdata[CLR_LSB +: NFLAG] : '0;
  end

  always_comb begin
    cfg_n  = cfg;
    halt_n = halt;
    en_n   = irq_en;
    if (wr_cfg && !busy) begin
      cfg_n.first         = reg_wdata[PTR_W-1:0];
      cfg_n.last          = reg_wdata[2*PTR_W-1:PTR_W];
      cfg_n.loop_en       = reg_wdata[8];
      cfg_n.loop_to_first = reg_wdata[9];
      cfg_n.cs_idle       = reg_wdata[10];
    end
    if (wr_halt) halt_n = reg_wdata[0];
    if (wr_irq)  en_n   = reg_wdata[NFLAG-1:0];
  end

  genvar g;
  generate
    for (g = 0; g < NFLAG; g++) begin : g_flag
      assign flags_n[g] = evt[g] | (flags[g] & ~clr[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      halt   <= 1'b0;
      flags  <= '0;
      irq_en <= '0;
    end else begin
      cfg    <= cfg_n;
      halt   <= halt_n;
      flags  <= flags_n;
      irq_en <= en_n;
    end
  end

  assign irq = |(flags & irq_en);
endmodule

// File: rtl/cmdq_fsm.sv
module cmdq_fsm
  import cmdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  seq_cfg_t         cfg,
  input  logic             halt,
  input  logic             cmd_done,
  output logic             busy,
  output logic [PTR_W-1:0] cur,
  output logic [PTR_W-1:0] done_ptr,
  output logic             evt_end,
  output logic             evt_abort
);
  seq_state_t       state, state_n;
  logic [PTR_W-1:0] cur_n, dp_n;
  logic             at_end;

  assign at_end = (cur == cfg.last);

  always_comb begin
    state_n   = state;
    cur_n     = cur;
    dp_n      = done_ptr;
    evt_end   = 1'b0;
    evt_abort = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (go) begin
          state_n = S_RUN;
          cur_n   = cfg.first;
        end
      end
      S_RUN: begin
        if (cmd_done) begin
          dp_n    = cur;
          evt_end = at_end;
          if (at_end && !cfg.loop_en) begin
            state_n = S_IDLE;
          end else if (halt) begin
            state_n   = S_IDLE;
            evt_abort = 1'b1;
          end else if (at_end) begin
            cur_n = cfg.loop_to_first ? cfg.first : '0;
          end else begin
            cur_n = cur + 1'b1;
          end
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur      <= '0;
      done_ptr <= '0;
    end else begin
      state    <= state_n;
      cur      <= cur_n;
      done_ptr <= dp_n;
    end
  end

  assign busy = (state == S_RUN);
endmodule

// File: rtl/cmdq_csel.sv
module cmdq_csel #(
  parameter int CS_W = 4
) (
  input  logic            busy,
  input  logic            idle_lvl,
  input  logic [CS_W-1:0] ent_cs,
  output logic [CS_W-1:0] cs_out
);
  genvar g;
  generate
    for (g = 0; g < CS_W; g++) begin : g_cs
      assign cs_out[g] = busy ? ent_cs[g] : idle_lvl;
    end
  endgenerate
endmodule

// File: rtl/cmdq_sequencer.sv
module cmdq_sequencer
  import cmdq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             go,
  output logic             cmd_valid,
  output logic [PTR_W-1:0] cmd_idx,
  input  logic             cmd_done,
  input  logic [CS_W-1:0]  ent_cs,
  output logic [CS_W-1:0]  cs_out,
  output logic             busy,
  output logic [PTR_W-1:0] done_ptr,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  seq_cfg_t         cfg;
  logic             halt, evt_end, evt_abort;
  logic [NFLAG-1:0] irq_en;

  cmdq_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .evt_end(evt_end),
    .evt_abort(evt_abort), .cfg(cfg), .halt(halt), .flags(flags),
    .irq_en(irq_en), .irq(irq)
  );

  cmdq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg(cfg), .halt(halt),
    .cmd_done(cmd_done), .busy(busy), .cur(cmd_idx), .done_ptr(done_ptr),
    .evt_end(evt_end), .evt_abort(evt_abort)
  );

  cmdq_csel #(.CS_W(CS_W)) u_cs (
    .busy(busy), .idle_lvl(cfg.cs_idle), .ent_cs(ent_cs), .cs_out(cs_out)
  );

  assign cmd_valid = busy;
endmodule

// File: rtl/cmdq_sequencer_chk.sv
module cmdq_sequencer_chk
  import cmdq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             busy,
  input logic             cmd_done,
  input logic [PTR_W-1:0] cmd_idx,
  input logic [PTR_W-1:0] done_ptr,
  input logic [NFLAG-1:0] flags,
  input logic [PTR_W-1:0] first,
  input logic [PTR_W-1:0] last,
  input logic             loop_en,
  input logic             loop_to_first,
  input logic             halt
);
  logic fin_stop;
  assign fin_stop = (cmd_idx == last) && !loop_en;

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> (busy && cmd_idx == $past(first)));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_done && cmd_idx != last && !halt) |=>
      (busy && cmd_idx == $past(cmd_idx) + 4'd1));

  p_stop_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_done && fin_stop) |=> !busy);

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_done && cmd_idx == last && loop_en && !halt) |=>
      (busy && cmd_idx == ($past(loop_to_first) ? $past(first) : 4'd0)));

  p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_done && halt && !fin_stop) |=> (!busy && flags[F_ABT]));

  p_done_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_done) |=> (done_ptr == $past(cmd_idx)));

  p_end_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_done && cmd_idx == last) |=> flags[F_END]);
endmodule

bind cmdq_sequencer cmdq_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .cmd_done(cmd_done),
  .cmd_idx(cmd_idx), .done_ptr(done_ptr), .flags(flags),
  .first(cfg.first), .last(cfg.last), .loop_en(cfg.loop_en),
  .loop_to_first(cfg.loop_to_first), .halt(halt)
);

// File: tb/tb_cmdq_sequencer.sv
module tb_cmdq_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_we, go, cmd_done, cmd_valid, busy, irq;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [3:0]  cmd_idx, ent_cs, cs_out, done_ptr;
  logic [2:0]  flags;

  int n_vec = 0, n_bad = 0, comp_cnt = 0, eng_cnt = 0;
  logic [3:0] exp_q[$];

  cmdq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .go(go), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
    .cmd_done(cmd_done), .ent_cs(ent_cs), .cs_out(cs_out), .busy(busy),
    .done_ptr(done_ptr), .flags(flags), .irq(irq)
  );

  assign ent_cs = ~cmd_idx;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // engine model + scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      cmd_done = 1'b0;
      eng_cnt  = 0;
    end else if (cmd_done) begin
      cmd_done = 1'b0;
      eng_cnt  = 0;
    end else if (cmd_valid) begin
      if (eng_cnt == 2) begin
        if (exp_q.size() == 0) chk("R1 unexpected entry", {12'd0, cmd_idx}, 16'hFFFF);
        else chk("R1/R2/R3 entry order", {12'd0, cmd_idx}, {12'd0, exp_q.pop_front()});
        chk("R6 cs follows entry", {12'd0, cs_out}, {12'd0, ~cmd_idx});
        cmd_done = 1'b1;
        eng_cnt  = 0;
        comp_cnt++;
      end else eng_cnt++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic start();
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    chk("R2/R4 queue stopped", {15'd0, busy}, 16'd0);
    chk("R1 all expected entries seen", exp_q.size(), 16'd0);
  endtask

  task automatic push(input logic [3:0] v);
    exp_q.push_back(v);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; go = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", {15'd0, busy}, 16'd0);
    chk("R10 cmd_valid", {15'd0, cmd_valid}, 16'd0);
    chk("R10 flags", {13'd0, flags}, 16'd0);
    chk("R10 irq", {15'd0, irq}, 16'd0);
    chk("R10 done_ptr", {12'd0, done_ptr}, 16'd0);
    chk("R10 cs_out", {12'd0, cs_out}, 16'd0);

    // R1 R2: ascending queue 2..5, no loop; R8 config write while busy
    wr(2'd0, 16'h0052);
    push(4'd2); push(4'd3); push(4'd4); push(4'd5);
    start();
    chk("R1 busy after go", {15'd0, busy}, 16'd1);
    wr(2'd0, 16'h0087);
    wait_idle();
    chk("R5 done_ptr", {12'd0, done_ptr}, 16'd5);
    chk("R7 R8 flags end+collision", {13'd0, flags}, 16'b011);
    chk("R9 irq all disabled", {15'd0, irq}, 16'd0);
    chk("R6 idle cs low", {12'd0, cs_out}, 16'h0);
    wr(2'd2, 16'h0002);
    chk("R9 irq collision enabled", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'h0070);
    chk("R7 w1c clears", {13'd0, flags}, 16'd0);
    chk("R9 irq after clear", {15'd0, irq}, 16'd0);

    // R8: the ignored write left pointers 2..5
    push(4'd2); push(4'd3); push(4'd4); push(4'd5);
    start();
    wait_idle();

    // R2 R6: crossing 15 -> 0, idle level high
    wr(2'd0, 16'h041E);
    chk("R6 idle cs high", {12'd0, cs_out}, 16'hF);
    push(4'd14); push(4'd15); push(4'd0); push(4'd1);
    start();
    wait_idle();
    chk("R5 done_ptr wrap", {12'd0, done_ptr}, 16'd1);
    chk("R6 idle cs high after run", {12'd0, cs_out}, 16'hF);

    // R4: halt before go runs only the first entry
    wr(2'd2, 16'h0070);
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0096);
    push(4'd6);
    start();
    wait_idle();
    chk("R4 abort only", {13'd0, flags}, 16'b100);
    chk("R5 done_ptr halt", {12'd0, done_ptr}, 16'd6);
    wr(2'd1, 16'h0000);

    // R3: loop to zero, halt after 4 completions
    wr(2'd2, 16'h0070);
    wr(2'd0, 16'h0143);
    push(4'd3); push(4'd4); push(4'd0); push(4'd1); push(4'd2);
    base = comp_cnt;
    start();
    wait (comp_cnt == base + 4);
    wr(2'd1, 16'h0001);
    wait_idle();
    chk("R4 R7 end+abort", {13'd0, flags}, 16'b101);
    chk("R5 done_ptr loop", {12'd0, done_ptr}, 16'd2);
    wr(2'd2, 16'h0007);
    chk("R9 irq enabled", {15'd0, irq}, 16'd1);
    wr(2'd2, 16'h0077);
    chk("R9 irq cleared", {15'd0, irq}, 16'd0);

    // R3: loop to first pointer, halt after 2 completions
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0343);
    push(4'd3); push(4'd4); push(4'd3);
    base = comp_cnt;
    start();
    wait (comp_cnt == base + 2);
    wr(2'd1, 16'h0001);
    wait_idle();
    chk("R3 R4 flags", {13'd0, flags}, 16'b101);
    chk("R5 done_ptr loop first", {12'd0, done_ptr}, 16'd3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule